// File: doc/BRIEF.md
# Page Translation Cache with Flush and Single-Page Invalidate

This block is a small, fully associative cache of virtual-to-physical page translations. It sits in front of a page table walker. Each cycle it compares a 20-bit virtual page number against every resident entry. In the same cycle it returns the physical frame number together with the writable, user-access, cache-inhibit and modified attributes of the matching entry. On a miss the walker fetches the page table word and installs it through the fill port. The block takes the frame and the attribute bits from that word itself.

Two kinds of invalidation are provided. A write to the page directory base register empties the whole cache. A single-page invalidate removes only the entry for one virtual page and leaves every other entry resident. A write access to a page whose modified attribute is still clear is reported as a miss, so the walker can set the modified bit in memory and install the updated word. New translations go into slots in round-robin order.

Top module: `xlate_cache`

## Requirements
- R1: A lookup hits in the same cycle when a valid entry's tag equals `lk_vpn`; the frame and attribute outputs then show that entry. On a miss, `lk_hit` and all data outputs are 0.
- R2: A fill decodes `fill_pte` as follows: frame = bits 31..12, writable = bit 1, user = bit 2, cache-inhibit = bit 6, modified = bit 8. A fill whose bit 0 (present) is 0 is ignored.
- R3: When `base_wr` is high, every entry is invalid after the next clock edge. A fill in the same cycle is dropped.
- R4: A single-page invalidate removes only the entry tagged `inv_vpn`, and every other entry stays valid. A fill of the same page in the same cycle is dropped. A fill of a different page in that cycle proceeds.
- R5: When `lk_write` is high, a match whose modified attribute is 0 is reported as a miss. A read of the same entry hits.
- R6: The cache has 8 entries. The victim pointer starts at slot 0 and advances by one, modulo 8, on each fill that allocates a new slot. After 8 further distinct fills, the oldest of them is evicted by the next one.
- R7: A fill of a page that is already resident rewrites that entry in place and leaves the victim pointer where it was, so no page is ever held twice.
- R8: After reset, every entry is invalid and the victim pointer is at slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_vpn | input | 20 | Virtual page number being translated |
| lk_write | input | 1 | The access being translated is a write |
| lk_hit | output | 1 | A usable translation was found |
| lk_frame | output | 20 | Physical frame number of the hit |
| lk_writable | output | 1 | Page is read-write |
| lk_user | output | 1 | Page is user-accessible |
| lk_nocache | output | 1 | Page is cache-inhibited |
| lk_dirty | output | 1 | Page is marked modified |
| fill_en | input | 1 | Install a translation |
| fill_vpn | input | 20 | Virtual page number of the fill |
| fill_pte | input | 32 | Page table word fetched by the walker |
| base_wr | input | 1 | Directory base register written: flush all |
| inv_en | input | 1 | Single-page invalidate request |
| inv_vpn | input | 20 | Virtual page to invalidate |

## Verification
Assertions check on every cycle that at most one entry matches a lookup, that a write hit always carries the modified attribute, and that a flush leaves nothing valid. They also check that an invalidate clears only its target slot, and that the victim pointer steps by exactly one on each allocation. Some behaviour shows only across a sequence of operations, and only the bench's scenarios can demonstrate it. That covers which page round-robin evicts, refill in place that leaves the pointer alone, a fill dropped against a same-cycle invalidate or flush, and the decoded field values. The bench checks these against its own reference model.

// File: rtl/xlate_pkg.sv
package xlate_pkg;

    localparam int VPN_W   = 20;
    localparam int PFN_W   = 20;
    localparam int PTE_W   = 32;
    localparam int ENTRIES = 8;

    // Page table word bit positions decoded on a fill
    localparam int PTE_PRESENT = 0;
    localparam int PTE_RW      = 1;
    localparam int PTE_USER    = 2;
    localparam int PTE_NOCACHE = 6;
    localparam int PTE_MODIFY  = 8;
    localparam int PTE_PFN_LSB = 12;

    typedef struct packed {
        logic [PFN_W-1:0] pfn;
        logic             rw;
        logic             user;
        logic             nocache;
        logic             dirty;
    } xl_attr_t;

    localparam int ATTR_W = $bits(xl_attr_t);

    function automatic xl_attr_t decode_pte(input logic [PTE_W-1:0] pte);
        xl_attr_t a;
        a.pfn     = pte[PTE_PFN_LSB +: PFN_W];
        a.rw      = pte[PTE_RW];
        a.user    = pte[PTE_USER];
        a.nocache = pte[PTE_NOCACHE];
        a.dirty   = pte[PTE_MODIFY];
        return a;
    endfunction

endpackage

// File: rtl/xlate_match.sv
module xlate_match #(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 20
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [VPN_W-1:0]              key,
    input  logic [ENTRIES-1:0][VPN_W-1:0] tags,
    input  logic [ENTRIES-1:0]            valid,
    output logic [ENTRIES-1:0]            hit,
    output logic                          any
);

    genvar g;
    generate
        for (g = 0; g < ENTRIES; g++) begin : g_cmp
            assign hit[g] = valid[g] && (tags[g] == key);
        end
    endgenerate

    assign any = |hit;

    // R7: a page is never resident twice, so a key can match at most one slot
    p_single_match_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit));

endmodule

// File: rtl/xlate_victim.sv
module xlate_victim #(
    parameter int ENTRIES = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     alloc,
    output logic [ENTRIES-1:0]       sel
);

    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    logic [IDX_W-1:0] ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (alloc) begin
            ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
        end
    end

    always_comb begin
        sel = '0;
        sel[ptr] = 1'b1;
    end

    // R6: each allocation moves the pointer on by exactly one slot, wrapping
    p_rr_step_r6: assert property (@(posedge clk) disable iff (rst)
        alloc |=> (ptr == (($past(ptr) == LAST) ? '0 : $past(ptr) + 1'b1)));

    // R6: without an allocation the pointer holds
    p_rr_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !alloc |=> $stable(ptr));

endmodule

// File: rtl/xlate_array.sv
module xlate_array
    import xlate_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 20
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          flush,
    input  logic [ENTRIES-1:0]            wr_sel,
    input  logic [VPN_W-1:0]              wr_tag,
    input  xl_attr_t                      wr_attr,
    input  logic [ENTRIES-1:0]            inv_sel,
    output logic [ENTRIES-1:0][VPN_W-1:0] tags,
    output xl_attr_t [ENTRIES-1:0]        attrs,
    output logic [ENTRIES-1:0]            valid
);

    genvar g;
    generate
        for (g = 0; g < ENTRIES; g++) begin : g_slot
            always_ff @(posedge clk) begin
                if (rst || flush) begin
                    valid[g] <= 1'b0;
                end else if (wr_sel[g]) begin
                    valid[g] <= 1'b1;
                end else if (inv_sel[g]) begin
                    valid[g] <= 1'b0;
                end
            end

            always_ff @(posedge clk) begin
                if (wr_sel[g] && !flush) begin
                    tags[g]  <= wr_tag;
                    attrs[g] <= wr_attr;
                end
            end
        end
    endgenerate

    // R3: a flush leaves no entry valid
    p_flush_empty_r3: assert property (@(posedge clk) disable iff (rst)
        flush |=> (valid == '0));

    // R4: an invalidated slot that was not rewritten is gone
    p_inv_clears_r4: assert property (@(posedge clk) disable iff (rst)
        !flush |=> ((valid & $past(inv_sel & ~wr_sel)) == '0));

    // R4: entries outside the invalidate stay resident
    p_inv_keeps_r4: assert property (@(posedge clk) disable iff (rst)
        !flush |=> ((~valid & $past(valid & ~inv_sel)) == '0));

endmodule

// File: rtl/xlate_cache.sv
module xlate_cache
    import xlate_pkg::*;
#(
    parameter int N_ENTRIES = xlate_pkg::ENTRIES,
    parameter int VPN_BITS  = xlate_pkg::VPN_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [VPN_BITS-1:0]  lk_vpn,
    input  logic                 lk_write,
    output logic                 lk_hit,
    output logic [PFN_W-1:0]     lk_frame,
    output logic                 lk_writable,
    output logic                 lk_user,
    output logic                 lk_nocache,
    output logic                 lk_dirty,
    input  logic                 fill_en,
    input  logic [VPN_BITS-1:0]  fill_vpn,
    input  logic [PTE_W-1:0]     fill_pte,
    input  logic                 base_wr,
    input  logic                 inv_en,
    input  logic [VPN_BITS-1:0]  inv_vpn
);

    logic [N_ENTRIES-1:0][VPN_BITS-1:0] tags;
    xl_attr_t [N_ENTRIES-1:0]           attrs;
    logic [N_ENTRIES-1:0]               valid;

    logic [N_ENTRIES-1:0] lk_match, fill_match, inv_match;
    logic                 lk_any, fill_any, inv_any;
    logic [N_ENTRIES-1:0] victim_sel, wr_sel, inv_sel;
    logic                 fill_ok, alloc;
    xl_attr_t             fill_attr, hit_attr;

    xlate_match #(.ENTRIES(N_ENTRIES), .VPN_W(VPN_BITS)) u_lk_match (
        .clk(clk), .rst(rst), .key(lk_vpn), .tags(tags), .valid(valid),
        .hit(lk_match), .any(lk_any));

    xlate_match #(.ENTRIES(N_ENTRIES), .VPN_W(VPN_BITS)) u_fill_match (
        .clk(clk), .rst(rst), .key(fill_vpn), .tags(tags), .valid(valid),
        .hit(fill_match), .any(fill_any));

    xlate_match #(.ENTRIES(N_ENTRIES), .VPN_W(VPN_BITS)) u_inv_match (
        .clk(clk), .rst(rst), .key(inv_vpn), .tags(tags), .valid(valid),
        .hit(inv_match), .any(inv_any));

    // Fill is dropped by a flush or by an invalidate of the same page
    assign fill_ok   = fill_en && fill_pte[PTE_PRESENT] && !base_wr &&
                       !(inv_en && (inv_vpn == fill_vpn));
    assign alloc     = fill_ok && !fill_any;
    assign wr_sel    = fill_ok ? (fill_any ? fill_match : victim_sel) : '0;
    assign inv_sel   = (inv_en && inv_any) ? inv_match : '0;
    assign fill_attr = decode_pte(fill_pte);

    xlate_victim #(.ENTRIES(N_ENTRIES)) u_victim (
        .clk(clk), .rst(rst), .alloc(alloc), .sel(victim_sel));

    xlate_array #(.ENTRIES(N_ENTRIES), .VPN_W(VPN_BITS)) u_array (
        .clk(clk), .rst(rst), .flush(base_wr), .wr_sel(wr_sel),
        .wr_tag(fill_vpn), .wr_attr(fill_attr), .inv_sel(inv_sel),
        .tags(tags), .attrs(attrs), .valid(valid));

    // One-hot AND-OR selection of the matching entry
    always_comb begin
        hit_attr = '0;
        for (int i = 0; i < N_ENTRIES; i++) begin
            if (lk_match[i]) hit_attr = hit_attr | attrs[i];
        end
    end

    always_comb begin
        lk_hit = lk_any && !(lk_write && !hit_attr.dirty);
        if (lk_hit) begin
            lk_frame    = hit_attr.pfn;
            lk_writable = hit_attr.rw;
            lk_user     = hit_attr.user;
            lk_nocache  = hit_attr.nocache;
            lk_dirty    = hit_attr.dirty;
        end else begin
            lk_frame    = '0;
            lk_writable = 1'b0;
            lk_user     = 1'b0;
            lk_nocache  = 1'b0;
            lk_dirty    = 1'b0;
        end
    end

    // R5: a write is only ever granted on a modified page
    p_write_dirty_r5: assert property (@(posedge clk) disable iff (rst)
        (lk_hit && lk_write) |-> lk_dirty);

    // R1: a miss drives all data outputs low
    p_miss_zero_r1: assert property (@(posedge clk) disable iff (rst)
        !lk_hit |-> (lk_frame == '0 && !lk_writable && !lk_user &&
                     !lk_nocache && !lk_dirty));

endmodule

// File: tb/xlate_cache_bench.sv
module xlate_cache_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic [19:0] lk_vpn;
    logic        lk_write;
    logic        lk_hit;
    logic [19:0] lk_frame;
    logic        lk_writable, lk_user, lk_nocache, lk_dirty;
    logic        fill_en;
    logic [19:0] fill_vpn;
    logic [31:0] fill_pte;
    logic        base_wr, inv_en;
    logic [19:0] inv_vpn;

    always #5 clk = ~clk;

    xlate_cache u_xlate_cache (
        .clk(clk), .rst(rst), .lk_vpn(lk_vpn), .lk_write(lk_write),
        .lk_hit(lk_hit), .lk_frame(lk_frame), .lk_writable(lk_writable),
        .lk_user(lk_user), .lk_nocache(lk_nocache), .lk_dirty(lk_dirty),
        .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_pte(fill_pte),
        .base_wr(base_wr), .inv_en(inv_en), .inv_vpn(inv_vpn));

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // Reference model
    logic [19:0] m_tag [8];
    logic [19:0] m_pfn [8];
    bit          m_v [8], m_rw [8], m_us [8], m_ci [8], m_md [8];
    int          m_ptr;

    function automatic logic [31:0] mk_pte(input logic [19:0] pfn, input bit rw,
                                           input bit us, input bit ci,
                                           input bit md, input bit v);
        logic [31:0] p = '0;
        p[31:12] = pfn; p[1] = rw; p[2] = us; p[6] = ci; p[8] = md; p[0] = v;
        return p;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 8; i++) m_v[i] = 1'b0;
        m_ptr = 0;
    endtask

    task automatic model_commit();
        int  res;
        bit  ok;
        if (base_wr) begin
            for (int i = 0; i < 8; i++) m_v[i] = 1'b0;
            return;
        end
        ok  = fill_en && fill_pte[0] && !(inv_en && inv_vpn == fill_vpn);
        res = -1;
        for (int i = 0; i < 8; i++) if (m_v[i] && m_tag[i] == fill_vpn) res = i;
        if (inv_en)
            for (int i = 0; i < 8; i++) if (m_v[i] && m_tag[i] == inv_vpn) m_v[i] = 1'b0;
        if (ok) begin
            int s = (res >= 0) ? res : m_ptr;
            if (res < 0) m_ptr = (m_ptr + 1) % 8;
            m_v[s] = 1'b1; m_tag[s] = fill_vpn; m_pfn[s] = fill_pte[31:12];
            m_rw[s] = fill_pte[1]; m_us[s] = fill_pte[2];
            m_ci[s] = fill_pte[6]; m_md[s] = fill_pte[8];
        end
    endtask

    // Compare lookup outputs with the model (R1, R5)
    task automatic check_model(input string req);
        bit eh = 1'b0; logic [19:0] ef = '0; bit erw = 0, eus = 0, eci = 0, emd = 0;
        for (int i = 0; i < 8; i++)
            if (m_v[i] && m_tag[i] == lk_vpn && !(lk_write && !m_md[i])) begin
                eh = 1'b1; ef = m_pfn[i]; erw = m_rw[i]; eus = m_us[i];
                eci = m_ci[i]; emd = m_md[i];
            end
        checks++;
        if ({lk_hit, lk_frame, lk_writable, lk_user, lk_nocache, lk_dirty} !==
            {eh, ef, erw, eus, eci, emd}) begin
            errors++;
            $display("FAIL %s vpn=%h wr=%0d: got hit=%0d frame=%h attr=%b%b%b%b, expected hit=%0d frame=%h attr=%b%b%b%b",
                     req, lk_vpn, lk_write, lk_hit, lk_frame, lk_writable, lk_user,
                     lk_nocache, lk_dirty, eh, ef, erw, eus, eci, emd);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        if (rst) model_reset(); else model_commit();
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        fill_en = 0; base_wr = 0; inv_en = 0; lk_write = 0;
    endtask

    task automatic do_op(input bit f, input logic [19:0] fv, input logic [31:0] fp,
                         input bit fl, input bit iv, input logic [19:0] ivv);
        fill_en = f; fill_vpn = fv; fill_pte = fp; base_wr = fl; inv_en = iv; inv_vpn = ivv;
        tick();
        idle_inputs();
    endtask

    task automatic probe(input logic [19:0] v, input bit w, input bit exp_hit,
                         input string req);
        lk_vpn = v; lk_write = w;
        #1;
        checks++;
        if (lk_hit !== exp_hit) begin
            errors++;
            $display("FAIL %s vpn=%h wr=%0d: hit=%0d expected %0d", req, v, w, lk_hit, exp_hit);
        end
        check_model(req);
        lk_write = 0;
    endtask

    logic [19:0] pool [12];

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        logic [19:0] g [10];
        void'($urandom(32'd7719));
        idle_inputs(); lk_vpn = '0; fill_vpn = '0; fill_pte = '0; inv_vpn = '0;
        rst = 1'b1;
        model_reset();
        @(negedge clk); tick(); tick();
        rst = 1'b0;

        // R8: empty after reset
        probe(20'h00000, 0, 0, "R8");
        probe(20'h12345, 0, 0, "R8");

        // R2: decode of the page table word
        do_op(1, 20'h00A01, mk_pte(20'hABCDE, 1, 0, 1, 1, 1), 0, 0, '0);
        probe(20'h00A01, 0, 1, "R2");
        checks++;
        if ({lk_frame, lk_writable, lk_user, lk_nocache, lk_dirty} !== {20'hABCDE, 4'b1011}) begin
            errors++;
            $display("FAIL R2 fields: got %h %b%b%b%b expected abcde 1011",
                     lk_frame, lk_writable, lk_user, lk_nocache, lk_dirty);
        end
        // R2: not-present word ignored
        do_op(1, 20'h00B02, mk_pte(20'h11111, 1, 1, 0, 1, 0), 0, 0, '0);
        probe(20'h00B02, 0, 0, "R2");

        // R5: write to clean page misses, read hits
        do_op(1, 20'h00C03, mk_pte(20'h22222, 1, 1, 0, 0, 1), 0, 0, '0);
        probe(20'h00C03, 0, 1, "R5");
        probe(20'h00C03, 1, 0, "R5");
        probe(20'h00A01, 1, 1, "R5");

        // R4: single-page invalidate keeps others
        do_op(0, '0, '0, 0, 1, 20'h00A01);
        probe(20'h00A01, 0, 0, "R4");
        probe(20'h00C03, 0, 1, "R4");
        // R4: same-page fill dropped, other-page fill proceeds
        do_op(1, 20'h00D04, mk_pte(20'h33333, 0, 0, 0, 1, 1), 0, 1, 20'h00D04);
        probe(20'h00D04, 0, 0, "R4");
        do_op(1, 20'h00E05, mk_pte(20'h44444, 0, 1, 1, 1, 1), 0, 1, 20'h00C03);
        probe(20'h00E05, 0, 1, "R4");
        probe(20'h00C03, 0, 0, "R4");

        // R3: flush beats a same-cycle fill
        do_op(1, 20'h00F06, mk_pte(20'h55555, 1, 1, 1, 1, 1), 1, 0, '0);
        probe(20'h00E05, 0, 0, "R3");
        probe(20'h00F06, 0, 0, "R3");

        // R6: round-robin eviction of the oldest
        for (int i = 0; i < 10; i++) g[i] = 20'h10000 + 20'(i * 3);
        for (int i = 0; i < 8; i++)
            do_op(1, g[i], mk_pte(20'(i + 20'h60), 1, 0, 0, 1, 1), 0, 0, '0);
        for (int i = 0; i < 8; i++) probe(g[i], 0, 1, "R6");
        do_op(1, g[8], mk_pte(20'h70, 1, 0, 0, 1, 1), 0, 0, '0);
        probe(g[0], 0, 0, "R6");
        probe(g[8], 0, 1, "R6");
        probe(g[1], 0, 1, "R6");

        // R7: refill in place, pointer unchanged
        do_op(1, g[1], mk_pte(20'h99999, 1, 1, 1, 1, 1), 0, 0, '0);
        probe(g[1], 0, 1, "R7");
        do_op(1, g[9], mk_pte(20'h71, 1, 0, 0, 1, 1), 0, 0, '0);
        probe(g[1], 0, 0, "R7");
        probe(g[2], 0, 1, "R7");

        // Random mix checked against the model (R1..R7)
        for (int i = 0; i < 12; i++) pool[i] = 20'hA5000 + 20'(i * 17);
        for (int n = 0; n < 3000; n++) begin
            int r = $urandom_range(99);
            fill_en  = (r < 45);
            fill_vpn = pool[$urandom_range(11)];
            fill_pte = {12'($urandom), 8'($urandom), 3'($urandom), 1'($urandom),
                        1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                        1'($urandom), 1'($urandom), 1'($urandom), ($urandom_range(9) != 0)};
            inv_en   = ($urandom_range(99) < 15);
            inv_vpn  = (r < 10) ? fill_vpn : pool[$urandom_range(11)];
            base_wr  = ($urandom_range(99) < 2);
            lk_vpn   = pool[$urandom_range(11)];
            lk_write = $urandom_range(1);
            #1;
            check_model("R1");
            tick();
        end
        idle_inputs();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule